// File: doc/BRIEF.md
# Floppy Write Precompensation Delay

This block shifts each write-data pulse in time on its way to a floppy drive, so that bit crowding on the inner tracks is offset. All of it runs on the 16 MHz master clock, and one clock period (62.5 ns) is the unit of time shift. When a rising edge appears on the raw write-data input, the block loads a down-counter with a preset. It releases a fixed-width output pulse once the counter has run out.

The preset depends on several inputs together:

- the early and late hints from the disk controller;
- the inner-track flag, which is set for tracks above 43;
- the density select, which is active low.

A nominal preset sits at the middle of the range. An early hint takes an amount away from it, and a late hint adds the same amount. There are two switch-set amounts: one for inner tracks and one, normally smaller, for outer tracks. In single density the hints are ignored and every pulse gets the nominal delay.

A pulse that arrives while a countdown is still running waits in a one-entry slot. Its own countdown starts at the release of the pulse ahead of it.

Top module: `wpc_delay_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wd_out` is low after that edge, and no pulse is produced later from stimulus seen before reset.
- R2: In double density (`dden_n`=0) with neither hint, the delay is D = BASE = 2^AMT_W-1. `wd_out` rises D+1 clock edges after the edge that first samples `wd_in` high.
- R3: In double density with only `early`=1, D = BASE - amt.
- R4: In double density with only `late`=1, D = BASE + amt.
- R5: With `early`=1 and `late`=1 together, D = BASE.
- R6: amt is `amt_inner` when `inner_trk`=1 and `amt_outer` when `inner_trk`=0.
- R7: In single density (`dden_n`=1), D = BASE whatever the values of `early`, `late` and the amounts.
- R8: Each release drives `wd_out` high for exactly PULSE_CYC (default 2) clock cycles.
- R9: A rising edge of `wd_in` that is sampled while a countdown is running is held, not dropped. Its D is taken from the hints at its own sampling edge. Its output rises D+1 edges after the edge on which the earlier pulse's output rose.
- R10: `wd_in` held high for many cycles gives exactly one output pulse; only its rising edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dden_n | input | 1 | Density select: 0 double, 1 single |
| inner_trk | input | 1 | 1 on tracks above 43 |
| early | input | 1 | Controller hint: write this bit early |
| late | input | 1 | Controller hint: write this bit late |
| amt_inner | input | AMT_W | Switch shift amount for inner tracks, in clocks |
| amt_outer | input | AMT_W | Switch shift amount for outer tracks, in clocks |
| wd_in | input | 1 | Raw write-data pulse, rising-edge active |
| wd_out | output | 1 | Delayed write pulse to the drive |

## Verification
Randomly spaced single pulses mix every combination of hints, track zone, density and switch amounts. Each output rise time is compared against a bench function of those inputs. This separates the early, late, nominal and both-hint presets, and it shows whether the inner or outer amount was selected. It also shows whether single density really masks the hints.

Directed cases cover the rest:
- extreme amounts of zero and full scale;
- a second pulse arriving mid-countdown, which tells a queued release apart from a dropped or an early one;
- a long-held input level, which tells edge detection apart from level retriggering;
- a reset in the middle of a countdown.

// File: rtl/wpc_pkg.sv
// Shared types for the write precompensation delay.
// Assumes hints are synchronous to the master clock.
package wpc_pkg;

    typedef enum logic [1:0] {
        HINT_NOM   = 2'd0,
        HINT_EARLY = 2'd1,
        HINT_LATE  = 2'd2
    } hint_e;

    // Reduce the two hints and the density select to one shift direction.
    function automatic hint_e decode_hint(input logic early, input logic late,
                                          input logic dden_n);
        if (dden_n)
            return HINT_NOM;
        else if (early && !late)
            return HINT_EARLY;
        else if (late && !early)
            return HINT_LATE;
        else
            return HINT_NOM;
    endfunction

endpackage

// File: rtl/wpc_sel.sv
// Preset selector: turns hints, track zone, density and switch amounts into a
// countdown preset. Purely combinational; assumes the amounts never exceed BASE.
module wpc_sel #(
    parameter int AMT_W = 2,
    parameter int BASE  = 3,
    parameter int DLY_W = 3
) (
    input  logic             early,
    input  logic             late,
    input  logic             inner_trk,
    input  logic             dden_n,
    input  logic [AMT_W-1:0] amt_inner,
    input  logic [AMT_W-1:0] amt_outer,
    output logic [DLY_W-1:0] dly
);
    import wpc_pkg::*;

    logic [AMT_W-1:0] amt;
    hint_e            hint;

    // Choose the zone amount and form the preset around the nominal value.
    always_comb begin
        amt  = inner_trk ? amt_inner : amt_outer;
        hint = decode_hint(early, late, dden_n);
        case (hint)
            HINT_EARLY: dly = DLY_W'(BASE) - DLY_W'(amt);
            HINT_LATE:  dly = DLY_W'(BASE) + DLY_W'(amt);
            default:    dly = DLY_W'(BASE);
        endcase
    end
endmodule

// File: rtl/wpc_cnt.sv
// Countdown engine: detects write-data rising edges, loads the preset, counts
// down and flags release at zero. One waiting slot holds a pulse that arrives
// mid-countdown; a further arrival while the slot is full replaces nothing.
module wpc_cnt #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_in,
    input  logic [DLY_W-1:0] dly,
    output logic             fire
);
    logic             wd_q;
    logic             busy;
    logic [DLY_W-1:0] cnt;
    logic             pend_vld;
    logic [DLY_W-1:0] pend_d;
    logic             rise;

    // Edge detect and release flag.
    always_comb begin
        rise = wd_in && !wd_q;
        fire = busy && (cnt == '0);
    end

    // Count down, release at zero, then load the waiting slot or a new edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q     <= 1'b0;
            busy     <= 1'b0;
            cnt      <= '0;
            pend_vld <= 1'b0;
            pend_d   <= '0;
        end else begin
            wd_q <= wd_in;
            if (busy) begin
                if (cnt == '0) begin
                    if (pend_vld) begin
                        cnt      <= pend_d;
                        pend_vld <= rise;
                        if (rise) pend_d <= dly;
                    end else if (rise) begin
                        cnt <= dly;
                    end else begin
                        busy <= 1'b0;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                    if (rise && !pend_vld) begin
                        pend_vld <= 1'b1;
                        pend_d   <= dly;
                    end
                end
            end else if (rise) begin
                busy <= 1'b1;
                cnt  <= dly;
            end
        end
    end

    // R9
    queue_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld |-> busy);

    // R2
    load_on_idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !busy) |=> (busy && cnt == $past(dly)));
endmodule

// File: rtl/wpc_pulse.sv
// Output shaper: stretches each release flag into a pulse of PULSE_CYC clocks.
// Assumes releases are at least PULSE_CYC+1 clocks apart in normal use.
module wpc_pulse #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic wr_out
);
    localparam int RW = $clog2(PULSE_CYC + 1);

    logic [RW-1:0] rem;

    // Load the width counter on release and run it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (fire)
            rem <= RW'(PULSE_CYC);
        else if (rem != '0)
            rem <= rem - 1'b1;
    end

    // Output is high while width remains.
    always_comb wr_out = (rem != '0);

    // R8
    fire_drives_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> wr_out);

    generate
        if (PULSE_CYC >= 2) begin : g_wide
            // R8
            min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(wr_out) |=> wr_out);
        end
    endgenerate
endmodule

// File: rtl/wpc_delay_top.sv
// Write precompensation delay top: preset selection, countdown with one
// waiting slot, and fixed-width output shaping on the 16 MHz master clock.
// Assumes all inputs are synchronous to clk.
module wpc_delay_top #(
    parameter int AMT_W     = 2,
    parameter int PULSE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dden_n,
    input  logic             inner_trk,
    input  logic             early,
    input  logic             late,
    input  logic [AMT_W-1:0] amt_inner,
    input  logic [AMT_W-1:0] amt_outer,
    input  logic             wd_in,
    output logic             wd_out
);
    localparam int BASE  = (1 << AMT_W) - 1;
    localparam int DLY_W = $clog2(2 * BASE + 1);

    logic [DLY_W-1:0] dly;
    logic             fire;

    wpc_sel #(.AMT_W(AMT_W), .BASE(BASE), .DLY_W(DLY_W)) sel_i (
        .early(early), .late(late), .inner_trk(inner_trk), .dden_n(dden_n),
        .amt_inner(amt_inner), .amt_outer(amt_outer), .dly(dly)
    );

    wpc_cnt #(.DLY_W(DLY_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .dly(dly), .fire(fire)
    );

    wpc_pulse #(.PULSE_CYC(PULSE_CYC)) pulse_i (
        .clk(clk), .rst_n(rst_n), .fire(fire), .wr_out(wd_out)
    );

    // R7
    single_density_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dden_n |-> (dly == DLY_W'(BASE)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !wd_out);
endmodule

// File: tb/wpc_delay_top_tb_top.sv
module wpc_delay_top_tb_top;
    localparam int CLK_PERIOD = 62;
    localparam int AMT_W      = 2;
    localparam int BASE       = 3;
    localparam int PULSE_CYC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dden_n = 1'b0, inner_trk = 1'b0, early = 1'b0, late = 1'b0, wd_in = 1'b0;
    logic [AMT_W-1:0] amt_inner = '0, amt_outer = '0;
    logic wd_out;

    int checks = 0, fails = 0;
    int cyc = 0;
    int exp_r [0:255];
    string exp_tag [0:255];
    int nexp = 0, nrise = 0;
    int last_r = 0;
    int width = 0;
    logic prev_out = 1'b0;
    bit done = 1'b0;

    wpc_delay_top #(.AMT_W(AMT_W), .PULSE_CYC(PULSE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .dden_n(dden_n), .inner_trk(inner_trk),
        .early(early), .late(late), .amt_inner(amt_inner), .amt_outer(amt_outer),
        .wd_in(wd_in), .wd_out(wd_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_delay(input bit e, input bit l, input bit inn, input bit dn,
                                     input int ai, input int ao);
        int a;
        a = inn ? ai : ao;
        if (dn) return BASE;
        if (e && !l) return BASE - a;
        if (l && !e) return BASE + a;
        return BASE;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Drive one pulse at a negedge; hold it high for 'hold' cycles, then low for 'gap'.
    task automatic send(input bit e, input bit l, input bit inn, input bit dn,
                        input int ai, input int ao, input int hold, input int gap,
                        input string tag);
        int a, d, r;
        early = e; late = l; inner_trk = inn; dden_n = dn;
        amt_inner = AMT_W'(ai); amt_outer = AMT_W'(ao);
        wd_in = 1'b1;
        a = cyc + 1;
        d = ref_delay(e, l, inn, dn, ai, ao);
        r = ((a > last_r) ? a : last_r) + d + 1;
        exp_tag[nexp] = (last_r >= a) ? "R9" : tag;
        exp_r[nexp] = r;
        nexp++;
        last_r = r;
        repeat (hold) @(negedge clk);
        wd_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Monitor: output rise times and widths.
    always @(negedge clk) begin
        if (rst_n && wd_out && !prev_out) begin
            if (nrise < nexp)
                check(cyc == exp_r[nrise], exp_tag[nrise], cyc, exp_r[nrise]);
            else
                check(1'b0, "R10 extra pulse", cyc, -1);
            nrise++;
        end
        if (wd_out) width++;
        if (rst_n && !wd_out && prev_out) begin
            check(width == PULSE_CYC, "R8 width", width, PULSE_CYC);
        end
        if (!wd_out) width = 0;
        prev_out <= wd_out;
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int ebit, lbit, ibit, dbit, ai, ao;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check(wd_out == 1'b0, "R1 reset", wd_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wd_out == 1'b0, "R1 after reset", wd_out, 0);

        // Directed presets, double density.
        send(0, 0, 0, 0, 2, 1, 2, 14, "R2");
        send(1, 0, 0, 0, 3, 1, 2, 14, "R3");
        send(1, 0, 0, 0, 0, 3, 2, 14, "R3");
        send(0, 1, 0, 0, 0, 3, 2, 14, "R4");
        send(0, 1, 0, 0, 3, 0, 2, 14, "R4");
        send(1, 1, 1, 0, 3, 3, 2, 14, "R5");
        send(1, 0, 1, 0, 3, 1, 2, 14, "R6");
        send(0, 1, 1, 0, 2, 0, 2, 14, "R6");
        send(1, 0, 1, 1, 3, 3, 2, 14, "R7");
        send(0, 1, 0, 1, 3, 3, 2, 14, "R7");

        // R9: second pulse arrives mid-countdown of a long first one.
        send(0, 1, 0, 0, 0, 3, 1, 1, "R4");
        send(0, 0, 0, 0, 0, 0, 1, 20, "R9");

        // R10: long held level gives one pulse.
        send(0, 0, 0, 0, 0, 0, 30, 14, "R10");

        // Random pulses, spaced so no countdowns overlap.
        for (int i = 0; i < 60; i++) begin
            ebit = $urandom % 2; lbit = $urandom % 2; ibit = $urandom % 2;
            dbit = (($urandom % 4) == 0) ? 1 : 0;
            ai = $urandom % 4; ao = $urandom % 4;
            send(ebit[0], lbit[0], ibit[0], dbit[0], ai, ao, 2, 14,
                 dbit != 0 ? "R7" : (ibit != 0 ? "R6" : "R2"));
        end

        repeat (20) @(negedge clk);
        check(nrise == nexp, "R10 pulse count", nrise, nexp);

        // R1: reset mid-countdown suppresses the pending release.
        early = 1'b0; late = 1'b1; dden_n = 1'b0; inner_trk = 1'b0; amt_outer = 2'd3;
        wd_in = 1'b1;
        @(negedge clk);
        wd_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (15) @(negedge clk);
        check(nrise == nexp, "R1 no release after reset", nrise, nexp);
        check(wd_out == 1'b0, "R1 output idle", wd_out, 0);

        done = 1'b1;
        finish_run();
    end
endmodule